// File: doc/BRIEF.md
# Precise Trap Commit Controller

This block decides, for an in-order five-stage pipeline, when a trap is taken and what state it leaves behind. Fault flags raised in fetch, decode or execute are not acted on where they arise. Each flag rides along with its instruction in a shadow of the pipeline registers, and all of them are judged together in one place: the memory stage, which is the commit point. A data-address fault raised in the memory stage itself joins them there. An external interrupt request is also sampled only at that point.

When the instruction at commit carries a flag, or an interrupt arrives while a valid instruction sits there, the block takes a trap. It raises kill for fetch, decode, execute and writeback. It redirects fetch to a fixed handler address, and it loads its cause and exception-PC registers. The exception PC is the address of the trapping instruction, so the handler can return to it and run it again. Everything older has already passed the commit point, and nothing younger ever reaches it. This makes every trap precise.

The pipeline is assumed to advance one stage every cycle. The surrounding datapath supplies the per-stage flags and the fetch PC. It uses `retire` to enable writeback and the kill outputs to squash its own stage registers.

Top module: `trap_commit_ctrl`

## Requirements
- R1: While reset is held and after its release, `commit_valid`, `redirect_valid` and `retire` are 0, and `cause_q` and `epc_q` read 0.
- R2: An instruction fetched with `if_valid` high in cycle t shows up at commit in cycle t+3, with `commit_valid` high and `commit_pc` equal to its fetch PC, unless a trap killed it first. No redirect happens in any cycle without a valid instruction at commit.
- R3: The trap of an older instruction takes precedence over every flag of a younger one. The younger instructions never reach commit.
- R4: When one instruction holds flags from several stages, the cause comes from the earliest stage, in the order fetch, decode, execute, memory. Cause codes are 4 bits: 0 interrupt, 1 illegal opcode (decode), 2 overflow (execute), 3 instruction address fault (fetch), 4 data address fault (memory).
- R5: `irq` high in a cycle with a valid instruction at commit takes a trap with cause 0, overriding any flag of that instruction. `irq` in a cycle with no valid instruction at commit has no effect.
- R6: In a trap cycle, `redirect_valid`, `kill_f`, `kill_d`, `kill_e` and `kill_wb` are all high and `redirect_pc` equals the HANDLER_PC parameter. `retire` is low in that cycle, so the trapping instruction does not write back.
- R7: At the clock edge that ends a trap cycle, `cause_q` takes the resolved cause and `epc_q` takes `commit_pc`. Both hold their values in every other cycle.
- R8: The instructions in fetch, decode and execute during a trap cycle never reach commit, and any flags they carry or receive are discarded. An instruction fetched in the next cycle commits three cycles later as normal.
- R9: `retire` is high exactly when a valid instruction is at commit and no trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetch stage holds an instruction this cycle |
| if_pc | input | XLEN | PC of the instruction in fetch |
| if_exc | input | 1 | Fetch-stage fault for that instruction |
| if_cause | input | CW | Cause code of the fetch fault |
| id_exc | input | 1 | Decode-stage fault for the instruction in decode |
| id_cause | input | CW | Cause code of the decode fault |
| ex_exc | input | 1 | Execute-stage fault for the instruction in execute |
| ex_cause | input | CW | Cause code of the execute fault |
| mem_exc | input | 1 | Memory-stage fault for the instruction at commit |
| mem_cause | input | CW | Cause code of the memory fault |
| irq | input | 1 | External interrupt request |
| kill_f | output | 1 | Squash fetch |
| kill_d | output | 1 | Squash decode |
| kill_e | output | 1 | Squash execute |
| kill_wb | output | 1 | Suppress writeback of the committing instruction |
| retire | output | 1 | Committing instruction may write back |
| commit_valid | output | 1 | A live instruction is at commit |
| commit_pc | output | XLEN | PC of the instruction at commit |
| redirect_valid | output | 1 | Trap taken; fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | Handler address |
| cause_q | output | CW | Cause register |
| epc_q | output | XLEN | Exception PC register |

## Verification
The assertions check the per-cycle rules on every cycle. A trap always raises every kill with the handler address and never retires. The cycle after a trap has an empty commit point. `epc_q` and `cause_q` change only after a trap, with an interrupt always leaving cause 0. A redirect never happens without a live instruction at commit. Only the bench's scenarios can show the ordering. These are the choice of cause among flags from different stages, the precedence of an older instruction over a younger one, and that flags driven onto killed stages are really discarded. Each of these needs a model of which instruction sits in which stage.

// File: rtl/trap_commit_ctrl.sv
module trap_commit_ctrl #(
  parameter int XLEN = 32,
  parameter int CW = 4,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid,
  input  logic [XLEN-1:0] if_pc,
  input  logic            if_exc,
  input  logic [CW-1:0]   if_cause,
  input  logic            id_exc,
  input  logic [CW-1:0]   id_cause,
  input  logic            ex_exc,
  input  logic [CW-1:0]   ex_cause,
  input  logic            mem_exc,
  input  logic [CW-1:0]   mem_cause,
  input  logic            irq,
  output logic            kill_f,
  output logic            kill_d,
  output logic            kill_e,
  output logic            kill_wb,
  output logic            retire,
  output logic            commit_valid,
  output logic [XLEN-1:0] commit_pc,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [CW-1:0]   cause_q,
  output logic [XLEN-1:0] epc_q
);

  localparam logic [CW-1:0] CAUSE_IRQ = '0;

  logic            d_v, e_v, m_v;
  logic [XLEN-1:0] d_pc, e_pc, m_pc;
  logic            d_x, e_x, m_x;
  logic [CW-1:0]   d_c, e_c, m_c;

  logic            m_hit, trap;
  logic [CW-1:0]   m_cause, trap_cause;

  assign m_hit      = m_x | mem_exc;
  assign m_cause    = m_x ? m_c : mem_cause;
  assign trap       = m_v & (irq | m_hit);
  assign trap_cause = irq ? CAUSE_IRQ : m_cause;

  assign kill_f         = trap;
  assign kill_d         = trap;
  assign kill_e         = trap;
  assign kill_wb        = trap;
  assign redirect_valid = trap;
  assign redirect_pc    = HANDLER_PC;
  assign retire         = m_v & ~trap;
  assign commit_valid   = m_v;
  assign commit_pc      = m_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_v <= 1'b0; e_v <= 1'b0; m_v <= 1'b0;
      d_x <= 1'b0; e_x <= 1'b0; m_x <= 1'b0;
      d_c <= '0;   e_c <= '0;   m_c <= '0;
      d_pc <= '0;  e_pc <= '0;  m_pc <= '0;
      cause_q <= '0;
      epc_q   <= '0;
    end else begin
      d_v  <= if_valid & ~trap;
      d_pc <= if_pc;
      d_x  <= if_valid & ~trap & if_exc;
      d_c  <= if_cause;

      e_v  <= d_v & ~trap;
      e_pc <= d_pc;
      e_x  <= d_v & ~trap & (d_x | id_exc);
      e_c  <= d_x ? d_c : id_cause;

      m_v  <= e_v & ~trap;
      m_pc <= e_pc;
      m_x  <= e_v & ~trap & (e_x | ex_exc);
      m_c  <= e_x ? e_c : ex_cause;

      if (trap) begin
        cause_q <= trap_cause;
        epc_q   <= m_pc;
      end
    end
  end

endmodule

// File: rtl/trap_commit_ctrl_chk.sv
module trap_commit_ctrl_chk #(
  parameter int XLEN = 32,
  parameter int CW = 4,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            kill_f,
  input logic            kill_d,
  input logic            kill_e,
  input logic            kill_wb,
  input logic            retire,
  input logic            commit_valid,
  input logic [XLEN-1:0] commit_pc,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic [CW-1:0]   cause_q,
  input logic [XLEN-1:0] epc_q
);

  AST_TRAP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (kill_f && kill_d && kill_e && kill_wb && !retire && redirect_pc == HANDLER_PC)); // R6

  AST_PIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !commit_valid); // R8

  AST_EPC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> epc_q == $past(commit_pc)); // R7

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_valid |=> ($stable(cause_q) && $stable(epc_q))); // R7

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && irq) |=> cause_q == CW'(0)); // R5

  AST_RETIRE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (commit_valid && !redirect_valid)); // R9

  AST_NO_EMPTY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_valid |-> !redirect_valid); // R2

endmodule

bind trap_commit_ctrl trap_commit_ctrl_chk #(
  .XLEN(XLEN), .CW(CW), .HANDLER_PC(HANDLER_PC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq),
  .kill_f(kill_f), .kill_d(kill_d), .kill_e(kill_e), .kill_wb(kill_wb),
  .retire(retire), .commit_valid(commit_valid), .commit_pc(commit_pc),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .cause_q(cause_q), .epc_q(epc_q)
);

// File: tb/trap_commit_ctrl_tb.sv
module trap_commit_ctrl_tb;
  localparam int XLEN = 32;
  localparam int CW = 4;
  localparam logic [31:0] HPC = 32'h0000_0180;
  localparam int NI = 6;
  localparam int NC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_valid = 0, if_exc = 0, id_exc = 0, ex_exc = 0, mem_exc = 0, irq = 0;
  logic [31:0] if_pc = '0;
  logic [3:0] if_cause = '0, id_cause = '0, ex_cause = '0, mem_cause = '0;
  logic kill_f, kill_d, kill_e, kill_wb, retire, commit_valid, redirect_valid;
  logic [31:0] commit_pc, redirect_pc, epc_q;
  logic [3:0] cause_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [3:0]    mk [0:NI-1];
  logic [NC-1:0] irqm;
  logic [3:0]    exp_cause = '0;
  logic [31:0]   exp_epc = '0;

  always #5 clk = ~clk;

  trap_commit_ctrl #(.XLEN(XLEN), .CW(CW), .HANDLER_PC(HPC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .if_valid(if_valid), .if_pc(if_pc), .if_exc(if_exc), .if_cause(if_cause),
    .id_exc(id_exc), .id_cause(id_cause), .ex_exc(ex_exc), .ex_cause(ex_cause),
    .mem_exc(mem_exc), .mem_cause(mem_cause), .irq(irq),
    .kill_f(kill_f), .kill_d(kill_d), .kill_e(kill_e), .kill_wb(kill_wb),
    .retire(retire), .commit_valid(commit_valid), .commit_pc(commit_pc),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .cause_q(cause_q), .epc_q(epc_q)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Stage order fetch, decode, execute, memory -> codes 3,1,2,4 (R4)
  function automatic logic [3:0] first_cause(input logic [3:0] m);
    if (m[0]) return 4'd3;
    if (m[1]) return 4'd1;
    if (m[2]) return 4'd2;
    return 4'd4;
  endfunction

  task automatic run_prog(input logic [31:0] base);
    logic [NI+3:0] killed;
    killed = '0;
    for (int k = 0; k < NC; k++) begin
      int j;
      bit ev, et;
      logic [3:0] ec;
      @(negedge clk);
      if_valid = (k < NI);
      if_pc    = base + 32'(4 * k);
      if_exc   = (k < NI) ? mk[k][0] : 1'b0;  if_cause  = 4'd3;
      id_exc   = (k >= 1 && k - 1 < NI) ? mk[k-1][1] : 1'b0; id_cause = 4'd1;
      ex_exc   = (k >= 2 && k - 2 < NI) ? mk[k-2][2] : 1'b0; ex_cause = 4'd2;
      mem_exc  = (k >= 3 && k - 3 < NI) ? mk[k-3][3] : 1'b0; mem_cause = 4'd4;
      irq      = irqm[k];
      #1;
      chk(cause_q == exp_cause, "R7 cause_q", 32'(cause_q), 32'(exp_cause));
      chk(epc_q == exp_epc, "R7 epc_q", epc_q, exp_epc);
      j  = k - 3;
      ev = (j >= 0) && (j < NI) && !killed[j];
      et = ev && (irq || mk[j] != 4'd0);
      ec = irq ? 4'd0 : first_cause(mk[j < 0 ? 0 : (j >= NI ? 0 : j)]);
      chk(commit_valid == ev, "R2/R3/R8 commit_valid", 32'(commit_valid), 32'(ev));
      if (ev) chk(commit_pc == base + 32'(4 * j), "R2 commit_pc", commit_pc, base + 32'(4 * j));
      chk(redirect_valid == et, "R5/R3 redirect_valid", 32'(redirect_valid), 32'(et));
      chk(retire == (ev && !et), "R9 retire", 32'(retire), 32'(ev && !et));
      chk({kill_f, kill_d, kill_e, kill_wb} == {4{et}}, "R6 kills",
          32'({kill_f, kill_d, kill_e, kill_wb}), 32'({4{et}}));
      if (et) begin
        chk(redirect_pc == HPC, "R6 redirect_pc", redirect_pc, HPC);
        exp_cause = ec;
        exp_epc   = base + 32'(4 * j);
        killed[j+1] = 1'b1; killed[j+2] = 1'b1; killed[j+3] = 1'b1;
      end
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < NI; i++) mk[i] = 4'd0;
    irqm = '0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int scen;
    scen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!commit_valid && !redirect_valid && !retire, "R1 outputs in reset",
        32'({commit_valid, redirect_valid, retire}), 32'd0);
    chk(cause_q == 4'd0 && epc_q == 32'd0, "R1 registers in reset", epc_q | 32'(cause_q), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!commit_valid && !redirect_valid, "R1 after release",
        32'({commit_valid, redirect_valid}), 32'd0);

    // Single instruction, every flag combination, with and without irq (R4, R5)
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 2; i++) begin
        clear_prog();
        mk[0] = 4'(m);
        irqm = (i != 0) ? 10'b00_0000_1000 : 10'b10_0000_0111;
        scen++;
        run_prog(32'h1000_0000 + 32'(scen * 64));
      end
    end

    // Two adjacent instructions, all flag pairs: age priority (R3, R8)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        clear_prog();
        mk[0] = 4'(a); mk[1] = 4'(b); mk[3] = 4'(b); mk[4] = 4'(a);
        scen++;
        run_prog(32'h2000_0000 + 32'(scen * 64));
      end
    end

    // Interrupt at each commit slot against a later overflow (R5, R8)
    for (int c = 3; c < NC; c++) begin
      clear_prog();
      mk[5] = 4'b0100;
      irqm[c] = 1'b1;
      scen++;
      run_prog(32'h3000_0000 + 32'(scen * 64));
    end

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule